// File: doc/BRIEF.md
# Truncating FMA Exponent Rounder with Late Anticipator Correction

This block is the exponent back end of a single-precision fused multiply-add pipe that rounds only toward zero. In its first cycle it adds two 8-bit operand exponents to a 10-bit signed adjustment term. The adjustment carries the bias and shift corrections. A carry-save step and a compound adder then give the pre-normalization exponent e together with e+1 and e+2. In its second cycle it takes the leading-zero count from the anticipator, a late flag saying the anticipator was off by one, and two zero flags from the fraction path. From these it produces the final biased exponent and a one-hot result-mux select: normal, true zero, or saturated maximum.

Both possible result exponents, e-lz and e-lz+1, are formed, each with its own overflow and underflow test and its own select set. The late error bit only picks one of two finished sets just before the output register. Subtraction of the count is done by adding its bitwise inverse to a precomputed increment, so no adder in the second cycle needs a carry-in. Results below the normal range flush to zero. The exponent-255 binade counts as ordinary normal numbers. Overflow saturates to exponent 255, and a sticky flag records range events.

Top module: `ern_exp_round`

## Requirements
- R1: With the anticipator error bit at 0, a non-special result whose value r = exp_a + exp_b + exp_adj - lz (exp_adj read as 10-bit two's complement) lies in 1..255 gives sel_o = 3'b001 (normal) and exp_o = r.
- R2: With the anticipator error bit at 1, the result value becomes r = exp_a + exp_b + exp_adj - lz + 1, with the same classification rules.
- R3: When r lies in 256..511 and no zero condition holds, sel_o = 3'b100 (saturate) and exp_o = 255.
- R4: When r <= 0, sel_o = 3'b010 (true zero) and exp_o = 0.
- R5: frac_zero_i or spec_zero_i forces sel_o = 3'b010 and exp_o = 0, overriding overflow and normal results.
- R6: r = 255 is a normal result (sel_o = 3'b001, exp_o = 255), not a saturation.
- R7: Exponents and valid_i are taken in cycle n. lz_i, lza_err_i and both zero flags belong to the same operation and are taken in cycle n+1. The result and valid_o appear in the cycle after that, and results come out in issue order.
- R8: range_flag_o goes high and stays high until reset after either of two results: a flush caused by underflow (r <= 0 with both zero flags low), or a normal result with exponent 255.
- R9: After reset, valid_o = 0, exp_o = 0, sel_o = 3'b010 and range_flag_o = 0.
- R10: A cycle without valid_i yields no valid_o, and its late inputs leave range_flag_o unchanged.
- R11: Callers keep r in -511..511. Exactly one select bit is high whenever valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation issued this cycle |
| exp_a_i | input | 8 | First multiplicand exponent (biased) |
| exp_b_i | input | 8 | Second multiplicand exponent (biased) |
| exp_adj_i | input | 10 | Signed bias and shift correction term |
| lz_i | input | 6 | Anticipated leading-zero count (one cycle after issue) |
| lza_err_i | input | 1 | Anticipator off by one; count one too large (one cycle after issue) |
| frac_zero_i | input | 1 | Fraction sum is zero (one cycle after issue) |
| spec_zero_i | input | 1 | Special operand case forces zero (one cycle after issue) |
| valid_o | output | 1 | Result valid |
| exp_o | output | 8 | Result exponent |
| sel_o | output | 3 | One-hot result select: bit0 normal, bit1 zero, bit2 saturate |
| range_flag_o | output | 1 | Sticky flush / extended-binade flag |

## Verification
Directed operations place r at each class edge: 0 and 1, 255 and 256, deep negative, and well inside the overflow band. These separate an off-by-one in the underflow sign test from one in the overflow bit test. Pairs with identical exponents but a different error bit show that the late mux picks the right candidate, including cases where the error bit alone moves a result across a boundary. Zero flags applied to would-be overflow and normal results check override priority. A reset mid-run followed by flushes with and without a zero flag checks the sticky flag's source. Random back-to-back and gapped traffic then checks ordering and the two-cycle alignment of early and late inputs.

// File: rtl/ern_pkg.sv
package ern_pkg;
  typedef enum logic [2:0] {
    SEL_NORM = 3'b001,
    SEL_ZERO = 3'b010,
    SEL_MAX  = 3'b100
  } rsel_t;
endpackage

// File: rtl/ern_precomp.sv
// Cycle-one exponent sum: carry-save compression of three terms, then a
// compound adder giving e, e+1 and e+2 side by side.
module ern_precomp #(
  parameter int XW = 8,
  parameter int EW = 10
) (
  input  logic [XW-1:0]         exp_a,
  input  logic [XW-1:0]         exp_b,
  input  logic [EW-1:0]         exp_adj,
  output logic [2:0][EW-1:0]    e_all
);
  logic [EW-1:0] a_x, b_x, s_v, c_v;

  always_comb begin
    a_x = {{(EW-XW){1'b0}}, exp_a};
    b_x = {{(EW-XW){1'b0}}, exp_b};
    s_v = a_x ^ b_x ^ exp_adj;
    c_v = ((a_x & b_x) | (a_x & exp_adj) | (b_x & exp_adj)) << 1;
  end

  for (genvar k = 0; k < 3; k++) begin : g_cmp
    assign e_all[k] = s_v + c_v + EW'(k);
  end
endmodule

// File: rtl/ern_cand.sv
// One candidate result for one assumed value of the anticipator error bit.
// base_hi + ~lz gives the candidate, base_lo + ~lz the candidate minus one.
module ern_cand
  import ern_pkg::*;
#(
  parameter int XW = 8,
  parameter int EW = 10
) (
  input  logic [EW-1:0] base_lo,
  input  logic [EW-1:0] base_hi,
  input  logic [EW-1:0] lz_inv,
  input  logic          frac_zero,
  input  logic          spec_zero,
  output rsel_t         sel,
  output logic [XW-1:0] res,
  output logic          evt
);
  logic [EW-1:0] r_v, rm1_v;
  logic unf, ovf, zero;

  always_comb begin
    r_v   = base_hi + lz_inv;
    rm1_v = base_lo + lz_inv;
    unf   = $signed(rm1_v) < 0;
    ovf   = (r_v[EW-1:EW-2] == 2'b01);
    zero  = unf | frac_zero | spec_zero;
    if (zero) begin
      sel = SEL_ZERO;
      res = '0;
    end else if (ovf) begin
      sel = SEL_MAX;
      res = '1;
    end else begin
      sel = SEL_NORM;
      res = r_v[XW-1:0];
    end
    evt = (unf & ~frac_zero & ~spec_zero) |
          (~zero & ~ovf & (r_v[XW-1:0] == {XW{1'b1}}));
  end
endmodule

// File: rtl/ern_exp_round.sv
module ern_exp_round
  import ern_pkg::*;
#(
  parameter int XW   = 8,
  parameter int LZ_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [XW-1:0]   exp_a_i,
  input  logic [XW-1:0]   exp_b_i,
  input  logic [XW+1:0]   exp_adj_i,
  input  logic [LZ_W-1:0] lz_i,
  input  logic            lza_err_i,
  input  logic            frac_zero_i,
  input  logic            spec_zero_i,
  output logic            valid_o,
  output logic [XW-1:0]   exp_o,
  output logic [2:0]      sel_o,
  output logic            range_flag_o
);
  localparam int EW = XW + 2;
  localparam int NC = 2;

  logic [2:0][EW-1:0] e_d, e_q;
  logic               v1;
  logic [EW-1:0]      lz_inv;
  rsel_t              c_sel [NC];
  logic [XW-1:0]      c_exp [NC];
  logic [NC-1:0]      c_evt;
  rsel_t              sel_n;
  logic [XW-1:0]      exp_n;
  logic               evt_n;

  ern_precomp #(.XW(XW), .EW(EW)) u_pre (
    .exp_a  (exp_a_i),
    .exp_b  (exp_b_i),
    .exp_adj(exp_adj_i),
    .e_all  (e_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      e_q <= '0;
    end else begin
      v1 <= valid_i;
      if (valid_i) e_q <= e_d;
    end
  end

  assign lz_inv = ~{{(EW-LZ_W){1'b0}}, lz_i};

  for (genvar k = 0; k < NC; k++) begin : g_cand
    ern_cand #(.XW(XW), .EW(EW)) u_cand (
      .base_lo  (e_q[k]),
      .base_hi  (e_q[k+1]),
      .lz_inv   (lz_inv),
      .frac_zero(frac_zero_i),
      .spec_zero(spec_zero_i),
      .sel      (c_sel[k]),
      .res      (c_exp[k]),
      .evt      (c_evt[k])
    );
  end

  always_comb begin
    sel_n = c_sel[lza_err_i];
    exp_n = c_exp[lza_err_i];
    evt_n = c_evt[lza_err_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o      <= 1'b0;
      exp_o        <= '0;
      sel_o        <= SEL_ZERO;
      range_flag_o <= 1'b0;
    end else begin
      valid_o <= v1;
      if (v1) begin
        sel_o        <= sel_n;
        exp_o        <= exp_n;
        range_flag_o <= range_flag_o | evt_n;
      end
    end
  end

  // R11: a single select line is active with every result
  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $countones(sel_o) == 1);
  // R4: the zero select carries a zero exponent
  assert_zero_exp_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o == SEL_ZERO) |-> exp_o == '0);
  // R3: the saturate select carries the top exponent
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o == SEL_MAX) |-> exp_o == {XW{1'b1}});
  // R1: a normal result never has a zero exponent
  assert_norm_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o == SEL_NORM) |-> exp_o != '0);
  // R8: the range flag is sticky
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(range_flag_o) |-> range_flag_o);
  // R10: an idle stage leaves no valid result and no flag change
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> (!valid_o && $stable(range_flag_o)));
endmodule

// File: tb/ern_exp_round_test.sv
module ern_exp_round_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, valid_i, lza_err_i, frac_zero_i, spec_zero_i;
  logic [7:0] exp_a_i, exp_b_i;
  logic [9:0] exp_adj_i;
  logic [5:0] lz_i;
  logic       valid_o, range_flag_o;
  logic [7:0] exp_o;
  logic [2:0] sel_o;

  ern_exp_round uut (
    .clk, .rst, .valid_i, .exp_a_i, .exp_b_i, .exp_adj_i, .lz_i,
    .lza_err_i, .frac_zero_i, .spec_zero_i,
    .valid_o, .exp_o, .sel_o, .range_flag_o
  );

  int n_run = 0, n_fail = 0;
  int q_exp[$];
  logic [2:0] q_sel[$];
  bit q_evt[$];
  string q_tag[$];
  bit flag_model = 0;

  // late inputs waiting for the cycle after issue
  logic [5:0] p_lz = 6'd63;
  bit p_err = 0, p_fz = 0, p_sz = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic apply_late();
    lz_i = p_lz; lza_err_i = p_err; frac_zero_i = p_fz; spec_zero_i = p_sz;
  endtask

  task automatic issue(int a, int b, int adj, int lz, bit err, bit fz, bit sz, string tag);
    int r;
    @(negedge clk);
    valid_i = 1'b1;
    exp_a_i = 8'(a); exp_b_i = 8'(b); exp_adj_i = 10'(adj);
    apply_late();
    p_lz = 6'(lz); p_err = err; p_fz = fz; p_sz = sz;
    r = a + b + adj - lz + (err ? 1 : 0);
    if (fz || sz || r <= 0) begin
      q_exp.push_back(0); q_sel.push_back(3'b010);
      q_evt.push_back(r <= 0 && !fz && !sz);
    end else if (r > 255) begin
      q_exp.push_back(255); q_sel.push_back(3'b100); q_evt.push_back(0);
    end else begin
      q_exp.push_back(r); q_sel.push_back(3'b001); q_evt.push_back(r == 255);
    end
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      apply_late();
      p_lz = 6'd63; p_err = 0; p_fz = 0; p_sz = 0;  // would flush if used
    end
  endtask

  task automatic drain();
    idle(1);
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst) flag_model = 0;
    else if (valid_o) begin
      if (q_exp.size() == 0) chk(0, "R10 unexpected valid_o", 1, 0);
      else begin
        int e; logic [2:0] s; bit v; string t;
        e = q_exp.pop_front(); s = q_sel.pop_front();
        v = q_evt.pop_front(); t = q_tag.pop_front();
        flag_model = flag_model | v;
        chk(exp_o == 8'(e), {t, " exp"}, int'(exp_o), e);
        chk(sel_o == s, {t, " sel"}, int'(sel_o), int'(s));
        chk(range_flag_o == flag_model, {"R8 flag after ", t},
            int'(range_flag_o), int'(flag_model));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; valid_i = 0; exp_a_i = 0; exp_b_i = 0; exp_adj_i = 0;
    apply_late();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(valid_o == 0, "R9 valid_o", int'(valid_o), 0);
    chk(exp_o == 0, "R9 exp_o", int'(exp_o), 0);
    chk(sel_o == 3'b010, "R9 sel_o", int'(sel_o), 2);
    chk(range_flag_o == 0, "R9 flag", int'(range_flag_o), 0);

    // R7 latency: late inputs one cycle after issue, result one after that
    issue(130, 140, -127, 10, 0, 0, 0, "R1 mid");
    idle(1);
    chk(valid_o == 0, "R7 early", int'(valid_o), 0);
    @(posedge clk); #3;
    chk(valid_o == 1, "R7 on time", int'(valid_o), 1);
    idle(3);
    chk(range_flag_o == 0, "R10 idle flag", int'(range_flag_o), 0);

    issue(130, 140, -127, 10, 1, 0, 0, "R2 mid");
    issue(60, 68, -127, 0, 0, 0, 0, "R1 r=1");
    issue(60, 68, -127, 1, 1, 0, 0, "R2 r=1 via err");
    issue(250, 250, -127, 5, 0, 0, 0, "R3 deep");
    issue(200, 183, -127, 0, 0, 0, 0, "R3 r=256");
    issue(200, 182, -127, 0, 1, 0, 0, "R3 r=256 via err");
    issue(250, 250, -127, 5, 0, 1, 0, "R5 fz over ovf");
    issue(130, 140, -127, 10, 0, 0, 1, "R5 sz over norm");
    issue(200, 182, -127, 1, 0, 0, 0, "R1 r=254");
    drain();
    chk(range_flag_o == 0, "R8 no event yet", int'(range_flag_o), 0);

    issue(200, 182, -127, 0, 0, 0, 0, "R6 r=255");
    drain();
    chk(range_flag_o == 1, "R8 set by 255", int'(range_flag_o), 1);

    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    #1 chk(range_flag_o == 0, "R9 flag cleared", int'(range_flag_o), 0);

    issue(10, 10, -127, 3, 0, 1, 0, "R4 neg with fz");
    issue(60, 67, -127, 0, 1, 0, 1, "R5 sz with err");
    drain();
    chk(range_flag_o == 0, "R8 fz flush no flag", int'(range_flag_o), 0);
    issue(60, 67, -127, 0, 0, 0, 0, "R4 r=0");
    issue(10, 10, -127, 40, 0, 0, 0, "R4 deep");
    drain();
    chk(range_flag_o == 1, "R8 set by flush", int'(range_flag_o), 1);

    for (int i = 0; i < 300; i++) begin
      issue($urandom_range(255), $urandom_range(255), -127 - int'($urandom_range(3)),
            $urandom_range(47), 1'($urandom_range(1)), ($urandom_range(15) == 0),
            ($urandom_range(15) == 0), "R7 random");
      if ($urandom_range(3) == 0) idle(1);
    end
    drain();
    chk(q_exp.size() == 0, "R7 all results seen", q_exp.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule